// File: doc/BRIEF.md
# Indirect Bus Command Bridge

This block lets a host that only has a 64-bit register port start single transfers on a 32-bit internal bus. The host sees four 64-bit registers: control, reset, status and data. Writing the control register starts one read or one write on the internal bus. The control word carries the direction, a byte count and a 32-bit target address. Write data comes from the data register. When a transfer finishes, the status register holds a done flag and, for reads, the returned word.

The internal bus uses a request that stays high until the target answers with ready or error. Only one transfer is in flight at a time, and the bus request itself serves as the busy flag. A failed read still reports done, with an all-ones data field. Reading the status register returns its value and clears it, so software polls it once per command. Commands whose byte count exceeds the limit are dropped without any effect.

All host accesses are full 64-bit words in big-endian order. The byte at the lowest bus address sits in the most significant byte of each 32-bit bus word.

Top module: `cmd_window_bridge`

## Requirements
- R1: Host address bits [4:3] select the register: 0 control, 1 reset, 2 status, 3 data; other address bits are ignored. Control and reset read as zero, and a write to reset has no effect.
- R2: A write to the data register stores bits [63:32] of the written word. A read of the data register returns the stored value in bits [63:32] with bits [31:0] zero.
- R3: A control write while idle, with byte count (bits [59:56]) of at most MAX_BYTES, raises bus_req on the next cycle. Alongside it, bus_addr carries control bits [31:0], bus_size carries the byte count, and bus_we is the inverse of control bit 48 (1 means read). For a write, bus_wdata equals the data register at launch.
- R4: A control write with a byte count above MAX_BYTES is dropped: no bus request is raised and the status register keeps its value.
- R5: bus_req stays high, with address, size, direction and write data stable, until a cycle in which bus_ready or bus_err is high. It is low on the following cycle.
- R6: A control write while a transfer is in flight is ignored. The current transfer is unchanged, and no second transfer follows it.
- R7: A read that completes with bus_ready and without bus_err sets status to bit 11 (done) plus the returned 32-bit word in bits [57:26]. All other bits are zero.
- R8: A read that completes with bus_err high (error wins over ready) sets status to bit 11 plus all ones in bits [57:26].
- R9: A completed write sets status to bit 11 alone, whether the bus answered with ready or error.
- R10: A status read returns the current value and clears the register to zero on that clock edge. If a transfer completes on that same edge, completion wins. Writes to status are ignored.
- R11: After reset, status and data read zero and bus_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host 64-bit register write strobe |
| reg_rd | input | 1 | Host 64-bit register read strobe (ignored when reg_wr is high) |
| reg_addr | input | REG_AW | Host byte address; bits [4:3] select the register |
| reg_wdata | input | 64 | Host write data |
| reg_rdata | output | 64 | Host read data, valid in the cycle reg_rd is high |
| bus_req | output | 1 | Internal bus request; also the busy flag |
| bus_we | output | 1 | 1 = write transfer, 0 = read transfer |
| bus_addr | output | 32 | Internal bus target address |
| bus_size | output | 4 | Transfer byte count |
| bus_wdata | output | 32 | Write data, most significant byte at the lowest address |
| bus_rdata | input | 32 | Read data returned by the target |
| bus_ready | input | 1 | Target completed the transfer |
| bus_err | input | 1 | Target failed the transfer |

## Verification
The bench builds the block with its defaults: MAX_BYTES of 8 and REG_AW of 8. Because of the limit of 8 inside a 4-bit count, random commands fall on both sides of the drop boundary about equally. With 8 address bits, the upper bits can be set to show that only bits [4:3] select a register. Random directions, response delays and error answers cover each way a transfer can end. Directed cases cover a command issued while busy, a dropped command that must keep a pending status, and status writes.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  // Register selected by host address bits [4:3]
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_RST  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DATA = 2'd3
  } cwb_sel_e;

  localparam int WORD_W      = 64;
  localparam int XFER_DW     = 32;
  localparam int XFER_AW     = 32;
  localparam int SIZE_W      = 4;
  localparam int SEL_LSB     = 3;
  localparam int CTRL_RD_BIT = 48;
  localparam int CTRL_SZ_LSB = 56;
  localparam int STAT_DONE   = 11;
  localparam int STAT_RD_LSB = 26;
  localparam int DATA_LSB    = 32;

  // Status word for a finished read
  function automatic logic [WORD_W-1:0] pack_read(input logic ok,
                                                  input logic [XFER_DW-1:0] rd);
    logic [WORD_W-1:0] w;
    logic [XFER_DW-1:0] field;
    field = ok ? rd : {XFER_DW{1'b1}};
    w = '0;
    w[STAT_DONE] = 1'b1;
    w[STAT_RD_LSB +: XFER_DW] = field;
    return w;
  endfunction

  // Status word for a finished write
  function automatic logic [WORD_W-1:0] pack_write();
    logic [WORD_W-1:0] w;
    w = '0;
    w[STAT_DONE] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/cwb_decode.sv
module cwb_decode
  import cwb_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  output cwb_sel_e          sel,
  output logic              wr_ctrl,
  output logic              wr_data,
  output logic              rd_stat
);
  logic rd_eff;
  logic unused_addr;

  assign sel         = cwb_sel_e'(reg_addr[SEL_LSB+1:SEL_LSB]);
  assign rd_eff      = reg_rd & ~reg_wr;
  assign wr_ctrl     = reg_wr & (sel == SEL_CTRL);
  assign wr_data     = reg_wr & (sel == SEL_DATA);
  assign rd_stat     = rd_eff & (sel == SEL_STAT);
  assign unused_addr = ^{reg_addr};
endmodule

// File: rtl/cwb_launch.sv
module cwb_launch
  import cwb_pkg::*;
#(
  parameter int MAX_BYTES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl,
  input  logic               ctrl_rd,
  input  logic [SIZE_W-1:0]  ctrl_size,
  input  logic [XFER_AW-1:0] ctrl_addr,
  input  logic [XFER_DW-1:0] data_q,
  input  logic               bus_ready,
  input  logic               bus_err,
  output logic               bus_req,
  output logic               bus_we,
  output logic [XFER_AW-1:0] bus_addr,
  output logic [SIZE_W-1:0]  bus_size,
  output logic [XFER_DW-1:0] bus_wdata,
  output logic               cmd_accept,
  output logic               cmd_drop,
  output logic               xfer_done,
  output logic               xfer_ok
);
  localparam logic [SIZE_W-1:0] MAX_SZ = SIZE_W'(MAX_BYTES);

  logic size_bad;

  assign size_bad   = ctrl_size > MAX_SZ;
  assign cmd_drop   = wr_ctrl & size_bad;
  assign cmd_accept = wr_ctrl & ~size_bad & ~bus_req;
  assign xfer_done  = bus_req & (bus_ready | bus_err);
  assign xfer_ok    = bus_ready & ~bus_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_size  <= '0;
      bus_wdata <= '0;
    end else if (cmd_accept) begin
      bus_req   <= 1'b1;
      bus_we    <= ~ctrl_rd;
      bus_addr  <= ctrl_addr;
      bus_size  <= ctrl_size;
      bus_wdata <= data_q;
    end else if (xfer_done) begin
      bus_req   <= 1'b0;
    end
  end
endmodule

// File: rtl/cwb_regs.sv
module cwb_regs
  import cwb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_data,
  input  logic [XFER_DW-1:0] wdata_hi,
  input  logic               rd_stat,
  input  logic               xfer_done,
  input  logic               xfer_we,
  input  logic               xfer_ok,
  input  logic [XFER_DW-1:0] bus_rdata,
  output logic [WORD_W-1:0]  stat_q,
  output logic [XFER_DW-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (xfer_done) begin
      stat_q <= xfer_we ? pack_write() : pack_read(xfer_ok, bus_rdata);
    end else if (rd_stat) begin
      stat_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) data_q <= '0;
    else if (wr_data) data_q <= wdata_hi;
  end
endmodule

// File: rtl/cmd_window_bridge.sv
module cmd_window_bridge
  import cwb_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int REG_AW    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  output logic               bus_req,
  output logic               bus_we,
  output logic [31:0]        bus_addr,
  output logic [3:0]         bus_size,
  output logic [31:0]        bus_wdata,
  input  logic [31:0]        bus_rdata,
  input  logic               bus_ready,
  input  logic               bus_err
);
  cwb_sel_e            sel;
  logic                wr_ctrl, wr_data, rd_stat;
  logic                cmd_accept, cmd_drop, xfer_done, xfer_ok;
  logic [WORD_W-1:0]   stat_q;
  logic [XFER_DW-1:0]  data_q;
  logic                unused_wd;

  assign unused_wd = ^{reg_wdata[63:60], reg_wdata[55:49], reg_wdata[47:32]};

  cwb_decode #(.REG_AW(REG_AW)) dec_i (
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .sel(sel), .wr_ctrl(wr_ctrl), .wr_data(wr_data), .rd_stat(rd_stat)
  );

  cwb_launch #(.MAX_BYTES(MAX_BYTES)) lau_i (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl),
    .ctrl_rd(reg_wdata[CTRL_RD_BIT]),
    .ctrl_size(reg_wdata[CTRL_SZ_LSB +: SIZE_W]),
    .ctrl_addr(reg_wdata[XFER_AW-1:0]),
    .data_q(data_q), .bus_ready(bus_ready), .bus_err(bus_err),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata),
    .cmd_accept(cmd_accept), .cmd_drop(cmd_drop),
    .xfer_done(xfer_done), .xfer_ok(xfer_ok)
  );

  cwb_regs reg_i (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
    .wdata_hi(reg_wdata[DATA_LSB +: XFER_DW]), .rd_stat(rd_stat),
    .xfer_done(xfer_done), .xfer_we(bus_we), .xfer_ok(xfer_ok),
    .bus_rdata(bus_rdata), .stat_q(stat_q), .data_q(data_q)
  );

  always_comb begin
    unique case (sel)
      SEL_STAT: reg_rdata = stat_q;
      SEL_DATA: reg_rdata = {data_q, {DATA_LSB{1'b0}}};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cwb_checker.sv
module cwb_checker
  import cwb_pkg::*;
#(
  parameter int MAX_BYTES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input cwb_sel_e           sel,
  input logic               reg_rd,
  input logic               reg_wr,
  input logic [63:0]        reg_rdata,
  input logic               bus_req,
  input logic               bus_we,
  input logic [31:0]        bus_addr,
  input logic [3:0]         bus_size,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic               bus_ready,
  input logic               bus_err,
  input logic               cmd_drop,
  input logic               rd_stat,
  input logic               xfer_done,
  input logic [WORD_W-1:0]  stat_q
);
  localparam logic [3:0] MAX_SZ = 4'(MAX_BYTES);

  AST_CTRL_RST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && (sel == SEL_CTRL || sel == SEL_RST)) |-> reg_rdata == '0); // R1
  AST_DATA_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && sel == SEL_DATA) |-> reg_rdata[31:0] == '0); // R2
  AST_SIZE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_size <= MAX_SZ); // R4
  AST_DROP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_drop && !bus_req) |=> !bus_req); // R4
  AST_DROP_KEEP_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_drop && !xfer_done && !rd_stat) |=> $stable(stat_q)); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready && !bus_err) |=> bus_req); // R5
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !bus_req); // R5
  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready && !bus_err) |=>
      ($stable(bus_addr) && $stable(bus_size) && $stable(bus_we) && $stable(bus_wdata))); // R6
  AST_READ_OK_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !bus_we && !bus_err) |=>
      (stat_q == pack_read(1'b1, $past(bus_rdata)))); // R7
  AST_READ_FAIL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !bus_we && bus_err) |=>
      (stat_q[57:26] == 32'hFFFF_FFFF && stat_q[11])); // R8
  AST_WRITE_DONE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && bus_we) |=> stat_q == 64'h800); // R9
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !xfer_done) |=> stat_q == '0); // R10
endmodule

bind cmd_window_bridge cwb_checker #(.MAX_BYTES(MAX_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel(sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_rdata(reg_rdata), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err),
  .cmd_drop(cmd_drop), .rd_stat(rd_stat), .xfer_done(xfer_done),
  .stat_q(stat_q)
);

// File: tb/cmd_window_bridge_tb_top.sv
`timescale 1ns/1ps
module cmd_window_bridge_tb_top;
  localparam int MAXB = 8;
  localparam logic [7:0] A_CTRL = 8'h00, A_RST = 8'h08, A_STAT = 8'h10, A_DATA = 8'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_size;
  logic [31:0] bus_rdata = '0;
  logic        bus_ready = 1'b0, bus_err = 1'b0;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  cmd_window_bridge #(.MAX_BYTES(MAXB), .REG_AW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .bus_err(bus_err)
  );

  // Control word: size in [59:56], read flag at 48, address in [31:0]
  function automatic logic [63:0] mk_ctrl(bit rd, logic [3:0] sz, logic [31:0] a);
    return {4'h0, sz, 7'h00, rd, 16'h0000, a};
  endfunction

  function automatic logic [63:0] exp_read(bit ok, logic [31:0] d);
    logic [63:0] v;
    v = ok ? ({32'h0, d} << 26) : (64'hFFFF_FFFF << 26);
    return v | 64'h800;
  endfunction

  task automatic chk(bit good, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic wr(logic [7:0] a, logic [63:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [63:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic respond(int w, bit ok, logic [31:0] d);
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      chk(bus_req == 1'b1, "R5 req held while waiting", 64'(bus_req), 64'd1);
    end
    bus_ready = ok; bus_err = ~ok; bus_rdata = d;
    @(negedge clk);
    bus_ready = 1'b0; bus_err = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] v, held;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(bus_req == 1'b0, "R11 req after reset", 64'(bus_req), 64'd0);
    rd(A_STAT, v); chk(v == 64'd0, "R11 status after reset", v, 64'd0);
    rd(A_DATA, v); chk(v == 64'd0, "R11 data after reset", v, 64'd0);

    // R2 data register, R1 aliasing through upper address bits
    wr(8'hF8, 64'hCAFE_F00D_1234_5678);
    rd(A_DATA, v); chk(v == 64'hCAFE_F00D_0000_0000, "R2 data readback", v, 64'hCAFE_F00D_0000_0000);
    rd(8'h38, v); chk(v == 64'hCAFE_F00D_0000_0000, "R1 alias upper bits", v, 64'hCAFE_F00D_0000_0000);
    wr(A_RST, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_RST, v); chk(v == 64'd0, "R1 reset reg reads zero", v, 64'd0);
    rd(A_CTRL, v); chk(v == 64'd0, "R1 ctrl reads zero", v, 64'd0);
    rd(A_DATA, v); chk(v == 64'hCAFE_F00D_0000_0000, "R1 reset write no effect", v, 64'hCAFE_F00D_0000_0000);

    // R6 control write while busy ignored
    wr(A_CTRL, mk_ctrl(1'b1, 4'd4, 32'hAAAA_0000));
    wr(A_CTRL, mk_ctrl(1'b0, 4'd2, 32'h5555_1111));
    chk(bus_addr == 32'hAAAA_0000 && bus_we == 1'b0, "R6 busy write ignored",
        {31'h0, bus_we, bus_addr}, {32'h0, 32'hAAAA_0000});
    respond(1, 1'b1, 32'h0BAD_BEEF);
    @(negedge clk);
    chk(bus_req == 1'b0, "R6 no second transfer", 64'(bus_req), 64'd0);

    // R4 dropped command keeps the pending status; R10 status write ignored
    held = exp_read(1'b1, 32'h0BAD_BEEF);
    wr(A_STAT, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(A_CTRL, mk_ctrl(1'b1, 4'd9, 32'h1));
    chk(bus_req == 1'b0, "R4 size 9 dropped", 64'(bus_req), 64'd0);
    rd(A_STAT, v); chk(v == held, "R4 R10 status kept", v, held);
    rd(A_STAT, v); chk(v == 64'd0, "R10 cleared on read", v, 64'd0);

    // R8 read failed with ready and error both high: error wins
    wr(A_CTRL, mk_ctrl(1'b1, 4'd8, 32'h10));
    bus_ready = 1'b1; bus_err = 1'b1; bus_rdata = 32'h1357_9BDF;
    @(negedge clk);
    bus_ready = 1'b0; bus_err = 1'b0;
    rd(A_STAT, v); chk(v == exp_read(1'b0, 0), "R8 error wins", v, exp_read(1'b0, 0));

    // Random mix
    for (int it = 0; it < 60; it++) begin
      bit rdir, ok;
      logic [3:0] sz;
      logic [31:0] a, dv, rdat;
      int w;
      logic [63:0] e;
      rdir = 1'($urandom); sz = 4'($urandom); a = $urandom; dv = $urandom;
      rdat = $urandom; w = int'($urandom % 4); ok = ($urandom % 4) != 0;
      wr(A_DATA, {dv, $urandom});
      wr(A_CTRL, mk_ctrl(rdir, sz, a));
      if (sz > 4'(MAXB)) begin
        chk(bus_req == 1'b0, "R4 oversize dropped", 64'(bus_req), 64'd0);
        rd(A_STAT, v); chk(v == 64'd0, "R4 status unchanged", v, 64'd0);
      end else begin
        chk(bus_req && bus_addr == a && bus_size == sz && bus_we == !rdir,
            "R3 launch fields", {bus_req, bus_we, 26'h0, bus_size, bus_addr},
            {1'b1, !rdir, 26'h0, sz, a});
        if (!rdir) chk(bus_wdata == dv, "R3 write data", 64'(bus_wdata), 64'(dv));
        respond(w, ok, rdat);
        chk(bus_req == 1'b0, "R5 req dropped after answer", 64'(bus_req), 64'd0);
        e = rdir ? exp_read(ok, rdat) : 64'h800;
        rd(A_STAT, v);
        if (!rdir) chk(v == e, "R9 write status", v, e);
        else if (ok) chk(v == e, "R7 read status", v, e);
        else chk(v == e, "R8 read failure status", v, e);
        rd(A_STAT, v); chk(v == 64'd0, "R10 clear after read", v, 64'd0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule